// File: doc/BRIEF.md
# Watchdog Timer with Interrupt and Reset Actions

This block is a watchdog driven by a slow tick-enable input. Software must strobe the kick input often enough to stop a counter from reaching the selected timeout. When the counter runs out, the block takes the action that its control register selects:

- do nothing;
- raise an interrupt;
- request a system reset;
- raise an interrupt first, and request a reset only if a second timeout follows with no kick in between.

A fuse-style input overrides the software enables and makes every timeout a reset request.

The control register sits on a simple write port with a combinational read-back. The timeout select and the reset enable are protected. They can only be changed during a short window that opens when software writes the unlock bit. The interrupt enable and the write-one-to-clear interrupt flag stay writable at all times. The timeout is `2^(BASE_LOG2 + sel)` ticks. The default `BASE_LOG2` of 11 gives 2048 ticks for select 0 and doubles for each step up to select 9. With a 128 kHz tick this spans roughly 16 ms to 8 s.

Top module: `wdog_top`

## Requirements
- R1: After `rst_ni` is released, `rd_data_o` is 0, and `irq_o` and `rst_req_o` are low.
- R2: The control register layout is: bits [3:0] timeout select, bit 4 reset enable, bit 5 interrupt enable, bit 6 unlock (reads as window open), bit 7 interrupt flag. For a select value s from 0 to 9, a timeout occurs on exactly the 2^(BASE_LOG2+s)-th tick (tick_i high at a clock edge) after a kick. The flag is set at that same edge.
- R3: Select values 10 to 15 behave as select 9.
- R4: A kick clears the tick count to 0, so the full timeout restarts from the kick.
- R5: A write with bit 6 set opens a window covering the next 4 clock cycles. The window closes after those 4 cycles whether or not a write occurs. Only a write inside the window updates the timeout select and the reset enable. The opening write itself and any later write leave them unchanged.
- R6: With the fuse input low and both enables clear, a timeout changes neither `irq_o` nor `rst_req_o`.
- R7: With the fuse input low and only the interrupt enable set, a timeout sets the flag, and `irq_o` follows the flag.
- R8: With the fuse input low and only the reset enable set, a timeout raises `rst_req_o` without setting the flag. `rst_req_o` stays high until `rst_ni` is asserted; a kick does not clear it.
- R9: With both enables set and the fuse input low, the first timeout sets the flag and clears the interrupt enable, leaving `rst_req_o` low. The next timeout without a kick raises `rst_req_o`.
- R10: With the fuse input high, a timeout raises `rst_req_o` and does not set the flag, whatever the enables are.
- R11: Writing 1 to bit 7 clears the flag, and writing 0 to it has no effect. The interrupt enable is written by every write, with or without the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Tick enable; one count per clock edge while high |
| kick_i | input | 1 | Restart strobe; clears the tick count |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control register write data |
| fuse_i | input | 1 | Forces every timeout to request a reset |
| rd_data_o | output | 8 | Control register read-back |
| irq_o | output | 1 | Interrupt request, equal to the flag |
| rst_req_o | output | 1 | Sticky system reset request |

## Verification
The hardest state to reach from the ports is the edge of the protected window. A write on the fourth cycle after unlocking must take effect, and a write on the fifth must not. The bench issues the unlock write and then waits a counted number of idle cycles before the payload write, using three idle cycles for one case and four for the other. It then reads the select field back. The second hard case is the two-stage interrupt-then-reset sequence, which needs two full timeouts in a row with no kick. Both are reached with the tick scaled down to `BASE_LOG2` = 2, so every select value can be swept to within one tick of its timeout.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam int          SEL_W   = 4;
  localparam logic [3:0]  SEL_MAX = 4'd9;
  localparam int          B_RST   = 4;
  localparam int          B_IE    = 5;
  localparam int          B_UNL   = 6;
  localparam int          B_FLG   = 7;

  function automatic logic [SEL_W-1:0] clamp_sel(input logic [SEL_W-1:0] s);
    return (s > SEL_MAX) ? SEL_MAX : s;
  endfunction
endpackage

// File: rtl/wdog_cfg.sv
`timescale 1ns/1ps
module wdog_cfg
  import wdog_pkg::*;
#(
  parameter int WIN_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  input  logic             set_flag_i,
  input  logic             clr_ie_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             rst_en_o,
  output logic             irq_en_o,
  output logic             flag_o,
  output logic             win_open_o
);
  localparam int WW = $clog2(WIN_CYC + 1);

  logic [WW-1:0] win_q;

  assign win_open_o = (win_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q    <= '0;
      sel_o    <= '0;
      rst_en_o <= 1'b0;
      irq_en_o <= 1'b0;
      flag_o   <= 1'b0;
    end else begin
      if (wr_en_i && wr_data_i[B_UNL]) win_q <= WW'(WIN_CYC);
      else if (win_open_o)             win_q <= win_q - 1'b1;

      // protected fields: only inside the window
      if (wr_en_i && win_open_o) begin
        sel_o    <= wr_data_i[SEL_W-1:0];
        rst_en_o <= wr_data_i[B_RST];
      end

      // hardware clear beats software write
      if (clr_ie_i)     irq_en_o <= 1'b0;
      else if (wr_en_i) irq_en_o <= wr_data_i[B_IE];

      // set beats write-one-to-clear
      if (set_flag_i)                        flag_o <= 1'b1;
      else if (wr_en_i && wr_data_i[B_FLG])  flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_cnt.sv
`timescale 1ns/1ps
module wdog_cnt
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             kick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tmo_o
);
  localparam int CW = BASE_LOG2 + 10;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] term;
  logic [CW-1:0] one_w;
  int            shamt;

  assign one_w = CW'(1);
  assign shamt = BASE_LOG2 + int'(clamp_sel(sel_i));
  assign term  = (one_w << shamt) - one_w;
  assign tmo_o = tick_i && !kick_i && (cnt_q == term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (kick_i)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= tmo_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdog_act.sv
`timescale 1ns/1ps
module wdog_act (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tmo_i,
  input  logic fuse_i,
  input  logic rst_en_i,
  input  logic irq_en_i,
  output logic set_flag_o,
  output logic clr_ie_o,
  output logic rst_req_o
);
  logic rst_fire;

  assign set_flag_o = tmo_i && !fuse_i && irq_en_i;
  // two-stage mode: drop to reset-only after the first interrupt
  assign clr_ie_o   = set_flag_o && rst_en_i;
  assign rst_fire   = tmo_i && (fuse_i || (rst_en_i && !irq_en_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rst_req_o <= 1'b0;
    else if (rst_fire) rst_req_o <= 1'b1;
  end
endmodule

// File: rtl/wdog_top.sv
`timescale 1ns/1ps
module wdog_top
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 11,
  parameter int WIN_CYC   = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       kick_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       fuse_i,
  output logic [7:0] rd_data_o,
  output logic       irq_o,
  output logic       rst_req_o
);
  logic [SEL_W-1:0] sel;
  logic             rst_en, irq_en, flag, win_open;
  logic             tmo, set_flag, clr_ie;

  wdog_cfg #(.WIN_CYC(WIN_CYC)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .set_flag_i(set_flag), .clr_ie_i(clr_ie),
    .sel_o(sel), .rst_en_o(rst_en), .irq_en_o(irq_en),
    .flag_o(flag), .win_open_o(win_open)
  );

  wdog_cnt #(.BASE_LOG2(BASE_LOG2)) u_cnt (
    .clk_i, .rst_ni, .tick_i, .kick_i, .sel_i(sel), .tmo_o(tmo)
  );

  wdog_act u_act (
    .clk_i, .rst_ni, .tmo_i(tmo), .fuse_i,
    .rst_en_i(rst_en), .irq_en_i(irq_en),
    .set_flag_o(set_flag), .clr_ie_o(clr_ie), .rst_req_o
  );

  assign rd_data_o = {flag, win_open, irq_en, rst_en, sel};
  assign irq_o     = flag;
endmodule

// File: rtl/wdog_chk.sv
`timescale 1ns/1ps
module wdog_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tmo_i,
  input logic       fuse_i,
  input logic [7:0] rd_data_i,
  input logic       irq_i,
  input logic       rst_req_i
);
  a_r5_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_i[6] |=> $stable(rd_data_i[4:0]));

  a_r5_window_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_data_i[6]) |-> $past(rd_data_i[6], 4));

  a_r6_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_i && !fuse_i && !rd_data_i[4] && !rd_data_i[5] |=> !$rose(irq_i) && !$rose(rst_req_i));

  a_r7_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_i && !fuse_i && rd_data_i[5] |=> irq_i);

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> rst_req_i);

  a_r9_first_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_i && !fuse_i && rd_data_i[5] && rd_data_i[4] |=> !rd_data_i[5] && (rst_req_i == $past(rst_req_i)));

  a_r10_fuse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_i && fuse_i |=> rst_req_i && !$rose(irq_i));
endmodule

bind wdog_top wdog_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tmo_i(tmo), .fuse_i(fuse_i),
  .rd_data_i(rd_data_o), .irq_i(irq_o), .rst_req_i(rst_req_o)
);

// File: tb/tb_wdog_top.sv
`timescale 1ns/1ps
module tb_wdog_top;
  localparam int BASE = 2;

  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, kick = 1'b0, wr = 1'b0, fuse = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] rd;
  logic       irq, rstq;
  int         checks = 0, fails = 0;

  wdog_top #(.BASE_LOG2(BASE), .WIN_CYC(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .kick_i(kick),
    .wr_en_i(wr), .wr_data_i(wd), .fuse_i(fuse),
    .rd_data_o(rd), .irq_o(irq), .rst_req_o(rstq)
  );

  always #2.5 clk = ~clk;

  function automatic int lim(input int s);
    return (1 << BASE) << ((s > 9) ? 9 : s);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic write(input logic [7:0] d);
    wr = 1'b1; wd = d; @(negedge clk); wr = 1'b0; wd = '0;
  endtask
  task automatic ticks(input int n);
    if (n > 0) begin tick = 1'b1; repeat (n) @(negedge clk); tick = 1'b0; end
  endtask
  task automatic do_kick();
    kick = 1'b1; @(negedge clk); kick = 1'b0;
  endtask
  task automatic do_reset();
    rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
  endtask
  task automatic prog(input int s, input logic re, input logic ie);
    write(8'h40);
    write({2'b00, ie, re, 4'(s)});
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(2); rst_n = 1'b1; idle(1);
    // R1
    chk("R1 rd", rd, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rst", rstq, 0);

    // R2/R3 sweep of every select value, interrupt-only mode
    for (int s = 0; s < 16; s++) begin
      prog(s, 1'b0, 1'b1);
      do_kick();
      ticks(lim(s) - 1);
      chk(s <= 9 ? "R2 early" : "R3 early", irq, 0);
      ticks(1);
      chk(s <= 9 ? "R2 on time" : "R3 on time", irq, 1);
      write(8'hA0 | 8'(s));
      chk("R11 w1c", irq, 0);
    end

    // R7/R11: flag repeats, a zero write to bit 7 keeps it
    prog(1, 1'b0, 1'b1);
    do_kick();
    ticks(8);
    chk("R7 flag", rd[7], 1);
    write(8'h21);
    chk("R11 zero write keeps flag", irq, 1);
    write(8'hA1);
    chk("R11 clear", irq, 0);

    // R4 kick restarts the count
    prog(2, 1'b0, 1'b1);
    do_kick();
    ticks(15);
    do_kick();
    ticks(15);
    chk("R4 no timeout after kick", irq, 0);
    ticks(1);
    chk("R4 timeout after full period", irq, 1);

    // R6 no action
    do_reset();
    prog(1, 1'b0, 1'b0);
    do_kick();
    ticks(20);
    chk("R6 irq", irq, 0);
    chk("R6 rst", rstq, 0);

    // R8 reset only, sticky
    prog(1, 1'b1, 1'b0);
    do_kick();
    ticks(7);
    chk("R8 early", rstq, 0);
    ticks(1);
    chk("R8 rst", rstq, 1);
    chk("R8 no flag", irq, 0);
    do_kick();
    idle(5);
    chk("R8 sticky", rstq, 1);
    do_reset();
    chk("R8 cleared by reset", rstq, 0);

    // R9 interrupt then reset
    prog(1, 1'b1, 1'b1);
    do_kick();
    ticks(8);
    chk("R9 flag", irq, 1);
    chk("R9 ie cleared", rd[5], 0);
    chk("R9 no rst yet", rstq, 0);
    ticks(7);
    chk("R9 second early", rstq, 0);
    ticks(1);
    chk("R9 second rst", rstq, 1);
    do_reset();

    // R10 fuse override
    fuse = 1'b1;
    prog(1, 1'b0, 1'b1);
    do_kick();
    ticks(8);
    chk("R10 rst", rstq, 1);
    chk("R10 no flag", irq, 0);
    fuse = 1'b0;
    do_reset();

    // R5 protected window edges
    write(8'h05);
    chk("R5 locked write", rd[4:0], 0);
    write(8'h40);
    chk("R5 window open", rd[6], 1);
    chk("R5 opening write no change", rd[4:0], 0);
    idle(3);
    write(8'h13);
    chk("R5 fourth cycle accepted", rd[4:0], 5'h13);
    chk("R5 window closed", rd[6], 0);
    write(8'h40);
    idle(4);
    write(8'h07);
    chk("R5 fifth cycle rejected", rd[4:0], 5'h13);
    write(8'h20);
    chk("R11 ie outside window", rd[5], 1);
    chk("R5 sel kept", rd[4:0], 5'h13);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule